// File: doc/BRIEF.md
# Software-Loaded Translation Lookaside Array

This block is a fully associative address translation array whose contents are loaded entirely by software. Each of its 64 slots is reached through an index and a two-bit word selector. Word 0 carries the effective page, the page-size code, an address-space bit and the valid bit. Word 1 carries the real page. Word 2 carries eight attribute bits and two permission triples, one for user mode and one for supervisor mode. A write to word 0 also stamps the entry with the process identifier currently held in the host's MMU control register. A read of word 0 hands that identifier back so the host can restore it.

A separate search port takes an effective address and a process identifier. One clock later it reports the lowest-numbered live entry that covers the address. Page sizes follow a power-of-four ladder that starts at 1 KiB. Whenever software rewrites a live mapping in a way that could make a cached translation stale, the block raises a one-cycle flush request. Host-side shadow translations can then be discarded.

Control sits in a two-state response machine. `CT_IDLE` means no answer is due. `CT_RESPOND` means a read or search strobe was taken on the previous edge and its answer is on the outputs. The transition `IDLE->RESPOND` fires on any read or search strobe. `RESPOND->RESPOND` fires on a back-to-back strobe. `RESPOND->IDLE` fires when no strobe arrives.

Top module: `swtlb_array`

## Requirements
- R1: The array holds 64 independent entries addressed by a 6-bit index; a write to one index leaves every other index unchanged.
- R2: A word 0 write takes the page from data bits 31:10, the size code from bits 7:4, the space bit from bit 8 and the valid bit from bit 9, and stamps the entry with `ctl_pid`. A word 0 read returns those fields at the same positions with bits 3:0 zero. It pulses `pid_echo_we` with the stored identifier on `pid_echo`.
- R3: A size code c in 0..10 gives a page of 1024 << (2*c) bytes. A code of 11..15 cannot be expressed in a 32-bit address, so it is stored as code 1 (4 KiB), and that is what reads back and what a search uses.
- R4: A word 1 write stores the data ANDed with 0xFFFFFC0F, and a word 1 read returns exactly that value.
- R5: A word 2 write stores attributes from bits 15:8 and permissions from bits 5:0. Bit 0 is user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write and bit 5 supervisor execute. It leaves page, size, space and valid untouched and never requests a flush. A word 2 read returns those bits with all others zero.
- R6: Word selector value 3 behaves exactly as word 0 for both writes and reads.
- R7: `flush_req` pulses in the cycle after a write, and only then, when the entry was valid before the write and one of these holds: a word 0 write changes the page, raises the size code, or clears the valid bit; or a word 1 write changes the stored real page.
- R8: `rd_valid` and `rd_data` appear exactly one cycle after `rd_en`. A read in the same cycle as a write returns the contents from before that write.
- R9: A search hits an entry that is valid, whose identifier equals `srch_pid` or is 0, and whose page equals the address with the bits below the page size cleared. The answer appears one cycle after `srch_req` and reflects the contents from before any same-cycle write.
- R10: When several entries hit, the lowest index is reported.
- R11: On a miss, `srch_hit` is low and `srch_idx` is all ones; an entry at index 63 that hits is told apart by `srch_hit` high.
- R12: After reset every entry is invalid with all fields zero, and no response or flush output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_idx | input | 6 | Entry index for reads and writes |
| cmd_word | input | 2 | Word selector (0, 1, 2; 3 aliases 0) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| ctl_pid | input | 8 | Current identifier from the MMU control register |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 32 | Read answer |
| pid_echo | output | 8 | Identifier of the entry read through word 0 |
| pid_echo_we | output | 1 | Load `pid_echo` into the MMU control register |
| srch_req | input | 1 | Search strobe |
| srch_addr | input | 32 | Effective address to look up |
| srch_pid | input | 8 | Identifier to match |
| srch_done | output | 1 | Search answer valid |
| srch_hit | output | 1 | Search found an entry |
| srch_idx | output | 6 | Index found, all ones on a miss |
| flush_req | output | 1 | One-cycle request to drop shadow translations |

## Verification
A search and a write to the same entry can be taken on the same clock edge. The search must then see the table as it was before the write. The bench provokes this by loading a fresh valid mapping on the very edge that carries a search for its address, and expects a miss, followed by a hit on the next search. In the same way, a read and a write of the same word are issued together. The bench expects the old value back, expects the new value on the read that follows, and checks the flush pulse that the overwrite of a live real page raises.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned PID_W     = 8;
    localparam int unsigned ATTR_W    = 8;
    localparam int unsigned PERM_W    = 3;
    localparam int unsigned SZ_W      = 4;
    localparam int unsigned PAGE_LSB  = 10;
    localparam int unsigned RLO_W     = 4;
    localparam int unsigned PAGE_W    = DATA_W - PAGE_LSB;
    localparam int unsigned SZ_LSB    = 4;
    localparam int unsigned SPACE_BIT = 8;
    localparam int unsigned VALID_BIT = 9;
    localparam int unsigned ATTR_LSB  = 8;
    localparam int unsigned SPERM_LSB = 3;
    localparam int unsigned MAX_SZ    = (DATA_W - PAGE_LSB - 1) / 2;
    localparam logic [SZ_W-1:0] FALLBACK_SZ = SZ_W'(1);

    typedef enum logic [1:0] {
        W_EPN  = 2'd0,
        W_RPN  = 2'd1,
        W_ATTR = 2'd2
    } word_e;

    typedef enum logic {
        CT_IDLE    = 1'b0,
        CT_RESPOND = 1'b1
    } ct_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SZ_W-1:0]   size;
        logic              space;
        logic              valid;
        logic [PID_W-1:0]  pid;
        logic [PAGE_W-1:0] rpn_hi;
        logic [RLO_W-1:0]  rpn_lo;
        logic [ATTR_W-1:0] attr;
        logic [PERM_W-1:0] uperm;
        logic [PERM_W-1:0] sperm;
    } entry_t;

    function automatic logic [SZ_W-1:0] norm_size(input logic [SZ_W-1:0] code);
        return (int'(code) > int'(MAX_SZ)) ? FALLBACK_SZ : code;
    endfunction

    function automatic logic [DATA_W-1:0] page_mask(input logic [SZ_W-1:0] code);
        logic [DATA_W-1:0] m;
        m = '1;
        m = m << (PAGE_LSB + 2 * int'(code));
        return m;
    endfunction
endpackage

// File: rtl/swtlb_entry.sv
module swtlb_entry
    import swtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  word_e             wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic [DATA_W-1:0] srch_addr,
    input  logic [PID_W-1:0]  srch_pid,
    output entry_t            ent,
    output logic              match,
    output logic              chg
);
    entry_t            e_q;
    logic [SZ_W-1:0]   new_sz;
    logic [PAGE_W-1:0] new_page;
    logic [DATA_W-1:0] masked;

    assign new_sz   = norm_size(wdata[SZ_LSB +: SZ_W]);
    assign new_page = wdata[DATA_W-1:PAGE_LSB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else if (we) begin
            unique case (wsel)
                W_EPN: begin
                    e_q.page  <= new_page;
                    e_q.size  <= new_sz;
                    e_q.space <= wdata[SPACE_BIT];
                    e_q.valid <= wdata[VALID_BIT];
                    e_q.pid   <= cur_pid;
                end
                W_RPN: begin
                    e_q.rpn_hi <= new_page;
                    e_q.rpn_lo <= wdata[RLO_W-1:0];
                end
                W_ATTR: begin
                    e_q.attr  <= wdata[ATTR_LSB +: ATTR_W];
                    e_q.uperm <= wdata[PERM_W-1:0];
                    e_q.sperm <= wdata[SPERM_LSB +: PERM_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        chg = 1'b0;
        if (e_q.valid) begin
            unique case (wsel)
                W_EPN:   chg = (new_page != e_q.page) || (new_sz > e_q.size)
                               || !wdata[VALID_BIT];
                W_RPN:   chg = ({new_page, wdata[RLO_W-1:0]} != {e_q.rpn_hi, e_q.rpn_lo});
                default: chg = 1'b0;
            endcase
        end
    end

    assign masked = srch_addr & page_mask(e_q.size);
    assign match  = e_q.valid
                  && ((e_q.pid == srch_pid) || (e_q.pid == '0))
                  && (masked == {e_q.page, {PAGE_LSB{1'b0}}});
    assign ent    = e_q;
endmodule

// File: rtl/swtlb_prio.sv
module swtlb_prio #(
    parameter int unsigned N = 64,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/swtlb_ctrl.sv
module swtlb_ctrl
    import swtlb_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              srch_req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rd_is_w0,
    input  logic [PID_W-1:0]  rd_pid,
    input  logic              hit_c,
    input  logic [IDX_W-1:0]  idx_c,
    input  logic              chg_c,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [PID_W-1:0]  pid_echo,
    output logic              pid_echo_we,
    output logic              srch_done,
    output logic              srch_hit,
    output logic [IDX_W-1:0]  srch_idx,
    output logic              flush_req
);
    ct_state_e         state_q, state_d;
    logic              rd_pend_q, srch_pend_q, w0_q, hit_q, flush_q;
    logic [DATA_W-1:0] data_q;
    logic [PID_W-1:0]  pid_q;
    logic [IDX_W-1:0]  idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE:    if (rd_en || srch_req) state_d = CT_RESPOND;
            CT_RESPOND: state_d = (rd_en || srch_req) ? CT_RESPOND : CT_IDLE;
            default:    state_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q   <= 1'b0;
            srch_pend_q <= 1'b0;
            w0_q        <= 1'b0;
            hit_q       <= 1'b0;
            flush_q     <= 1'b0;
            data_q      <= '0;
            pid_q       <= '0;
            idx_q       <= '1;
        end else begin
            rd_pend_q   <= rd_en;
            srch_pend_q <= srch_req;
            flush_q     <= wr_en && chg_c;
            if (rd_en) begin
                data_q <= rd_word;
                w0_q   <= rd_is_w0;
                pid_q  <= rd_pid;
            end
            if (srch_req) begin
                hit_q <= hit_c;
                idx_q <= idx_c;
            end
        end
    end

    always_comb begin
        rd_valid    = (state_q == CT_RESPOND) && rd_pend_q;
        rd_data     = rd_valid ? data_q : '0;
        pid_echo_we = rd_valid && w0_q;
        pid_echo    = pid_echo_we ? pid_q : '0;
        srch_done   = (state_q == CT_RESPOND) && srch_pend_q;
        srch_hit    = srch_done && hit_q;
        srch_idx    = srch_hit ? idx_q : '1;
        flush_req   = flush_q;
    end
endmodule

// File: rtl/swtlb_array.sv
module swtlb_array
    import swtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [1:0]        cmd_word,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PID_W-1:0]  ctl_pid,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [PID_W-1:0]  pid_echo,
    output logic              pid_echo_we,
    input  logic              srch_req,
    input  logic [DATA_W-1:0] srch_addr,
    input  logic [PID_W-1:0]  srch_pid,
    output logic              srch_done,
    output logic              srch_hit,
    output logic [IDX_W-1:0]  srch_idx,
    output logic              flush_req
);
    word_e              wsel;
    entry_t             ents [ENTRIES];
    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] chgs;
    entry_t             sel;
    logic [DATA_W-1:0]  rd_word;
    logic               hit_c;
    logic [IDX_W-1:0]   idx_c;

    assign wsel = (cmd_word == 2'd3) ? W_EPN : word_e'(cmd_word);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        swtlb_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (wr_en && (cmd_idx == IDX_W'(g))),
            .wsel      (wsel),
            .wdata     (wr_data),
            .cur_pid   (ctl_pid),
            .srch_addr (srch_addr),
            .srch_pid  (srch_pid),
            .ent       (ents[g]),
            .match     (hits[g]),
            .chg       (chgs[g])
        );
    end

    assign sel = ents[cmd_idx];

    always_comb begin
        rd_word = '0;
        unique case (wsel)
            W_EPN: begin
                rd_word[DATA_W-1:PAGE_LSB] = sel.page;
                rd_word[VALID_BIT]         = sel.valid;
                rd_word[SPACE_BIT]         = sel.space;
                rd_word[SZ_LSB +: SZ_W]    = sel.size;
            end
            W_RPN: begin
                rd_word[DATA_W-1:PAGE_LSB] = sel.rpn_hi;
                rd_word[RLO_W-1:0]         = sel.rpn_lo;
            end
            W_ATTR: begin
                rd_word[ATTR_LSB +: ATTR_W]  = sel.attr;
                rd_word[SPERM_LSB +: PERM_W] = sel.sperm;
                rd_word[PERM_W-1:0]          = sel.uperm;
            end
            default: rd_word = '0;
        endcase
    end

    swtlb_prio #(.N(ENTRIES)) u_prio (
        .req   (hits),
        .found (hit_c),
        .idx   (idx_c)
    );

    swtlb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .srch_req    (srch_req),
        .wr_en       (wr_en),
        .rd_word     (rd_word),
        .rd_is_w0    (wsel == W_EPN),
        .rd_pid      (sel.pid),
        .hit_c       (hit_c),
        .idx_c       (idx_c),
        .chg_c       (chgs[cmd_idx]),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .pid_echo    (pid_echo),
        .pid_echo_we (pid_echo_we),
        .srch_done   (srch_done),
        .srch_hit    (srch_hit),
        .srch_idx    (srch_idx),
        .flush_req   (flush_req)
    );
endmodule

// File: rtl/swtlb_array_chk.sv
module swtlb_array_chk
    import swtlb_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        cmd_word,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              pid_echo_we,
    input logic              srch_req,
    input logic              srch_done,
    input logic              srch_hit,
    input logic [IDX_W-1:0]  srch_idx,
    input logic              flush_req
);
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R8
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R8
    AST_SRCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) srch_req |=> srch_done); // R9
    AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_done && !srch_hit) |-> (srch_idx == '1)); // R11
    AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> !flush_req); // R7
    AST_ATTR_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_word == 2'd2) |=> !flush_req); // R5
    AST_ECHO_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n) pid_echo_we |-> rd_valid); // R2
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pid_echo_we |-> (int'(rd_data[SZ_LSB +: SZ_W]) <= int'(MAX_SZ))); // R3
endmodule

bind swtlb_array swtlb_array_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cmd_word    (cmd_word),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .pid_echo_we (pid_echo_we),
    .srch_req    (srch_req),
    .srch_done   (srch_done),
    .srch_hit    (srch_hit),
    .srch_idx    (srch_idx),
    .flush_req   (flush_req)
);

// File: tb/swtlb_array_tb_top.sv
`timescale 1ns/1ps
module swtlb_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [1:0]  cmd_word = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  ctl_pid = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  pid_echo;
    logic        pid_echo_we;
    logic        srch_req = 1'b0;
    logic [31:0] srch_addr = '0;
    logic [7:0]  srch_pid = '0;
    logic        srch_done;
    logic        srch_hit;
    logic [5:0]  srch_idx;
    logic        flush_req;

    always #4 clk = ~clk;

    swtlb_array dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_idx(cmd_idx), .cmd_word(cmd_word),
        .wr_en(wr_en), .wr_data(wr_data), .ctl_pid(ctl_pid), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .pid_echo(pid_echo),
        .pid_echo_we(pid_echo_we), .srch_req(srch_req), .srch_addr(srch_addr),
        .srch_pid(srch_pid), .srch_done(srch_done), .srch_hit(srch_hit),
        .srch_idx(srch_idx), .flush_req(flush_req)
    );

    typedef struct {
        int          due;
        int          kind;   // 0 read, 1 search, 2 flush
        logic [31:0] exp;
        logic [7:0]  exp_pid;
        logic        w0;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops every item due in this cycle and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            case (it.kind)
                0: begin
                    if (!rd_valid || rd_data !== it.exp || pid_echo_we !== it.w0
                        || (it.w0 && pid_echo !== it.exp_pid)) begin
                        n_fail++;
                        $display("FAIL %s read: got v=%b d=%h we=%b pid=%h exp d=%h we=%b pid=%h",
                                 it.tag, rd_valid, rd_data, pid_echo_we, pid_echo,
                                 it.exp, it.w0, it.exp_pid);
                    end
                end
                1: begin
                    if (!srch_done || {srch_hit, srch_idx} !== it.exp[6:0]) begin
                        n_fail++;
                        $display("FAIL %s search: got done=%b hit=%b idx=%0d exp hit=%b idx=%0d",
                                 it.tag, srch_done, srch_hit, srch_idx, it.exp[6], it.exp[5:0]);
                    end
                end
                default: begin
                    if (flush_req !== it.exp[0]) begin
                        n_fail++;
                        $display("FAIL %s flush: got %b exp %b", it.tag, flush_req, it.exp[0]);
                    end
                end
            endcase
        end
    end

    task automatic op(input bit w, input bit r, input bit s, input logic [5:0] idx,
                      input logic [1:0] word, input logic [31:0] wd, input logic [7:0] cpid,
                      input logic [31:0] sa, input logic [7:0] sp);
        @(negedge clk);
        wr_en = w; rd_en = r; srch_req = s;
        cmd_idx = idx; cmd_word = word; wr_data = wd; ctl_pid = cpid;
        srch_addr = sa; srch_pid = sp;
    endtask

    function automatic void push(input int kind, input logic [31:0] e, input logic [7:0] p,
                                 input logic w0, input string tag);
        item_t it;
        it.due = cyc + 1; it.kind = kind; it.exp = e; it.exp_pid = p; it.w0 = w0; it.tag = tag;
        q.push_back(it);
    endfunction

    task automatic wr(input logic [5:0] idx, input logic [1:0] word, input logic [31:0] d,
                      input logic [7:0] cpid, input bit fl, input string tag);
        op(1, 0, 0, idx, word, d, cpid, 0, 0);
        push(2, {31'd0, fl}, 0, 0, tag);
    endtask

    task automatic rd(input logic [5:0] idx, input logic [1:0] word, input logic [31:0] e,
                      input logic [7:0] p, input string tag);
        op(0, 1, 0, idx, word, 0, 0, 0, 0);
        push(0, e, p, (word == 2'd0 || word == 2'd3), tag);
    endtask

    task automatic sr(input logic [31:0] a, input logic [7:0] p, input bit h,
                      input logic [5:0] idx, input string tag);
        op(0, 0, 1, 0, 0, 0, 0, a, p);
        push(1, {25'd0, h, idx}, 0, 0, tag);
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R12: reset state
        sr(32'h0000_0000, 8'h00, 0, 6'h3F, "R12_R11 empty search");
        rd(6'd5, 2'd0, 32'h0, 8'h00, "R12 entry cleared");
        // R2: word 0 fields, junk in bits 3:0 dropped
        wr(6'd5, 2'd0, 32'h0001_031F, 8'h22, 0, "R7 write to invalid entry");
        rd(6'd5, 2'd0, 32'h0001_0310, 8'h22, "R2 word0 readback");
        // R4 + R7: real page change on live entry
        wr(6'd5, 2'd1, 32'hABCD_E7FF, 8'h00, 1, "R7 real page change");
        rd(6'd5, 2'd1, 32'hABCD_E40F, 8'h00, "R4 word1 mask");
        wr(6'd5, 2'd1, 32'hABCD_E40F, 8'h00, 0, "R7 same real page");
        // R5: attributes and permissions
        wr(6'd5, 2'd2, 32'hFFFF_FFFF, 8'h00, 0, "R5 word2 no flush");
        rd(6'd5, 2'd2, 32'h0000_FF3F, 8'h00, "R5 word2 readback");
        rd(6'd5, 2'd0, 32'h0001_0310, 8'h22, "R5 valid preserved");
        rd(6'd5, 2'd3, 32'h0001_0310, 8'h22, "R6 word3 alias read");
        // R9 search basics, R3 4 KiB page limit
        sr(32'h0001_0ABC, 8'h22, 1, 6'd5, "R9 pid hit");
        sr(32'h0001_0ABC, 8'h33, 0, 6'h3F, "R9 pid mismatch");
        sr(32'h0001_1000, 8'h22, 0, 6'h3F, "R3 outside 4K page");
        // R10: global 16K entry at lower index
        wr(6'd2, 2'd0, 32'h0001_0220, 8'h00, 0, "R7 invalid target");
        sr(32'h0001_3FFC, 8'h77, 1, 6'd2, "R3_R9 global 16K hit");
        sr(32'h0001_0ABC, 8'h22, 1, 6'd2, "R10 lowest index");
        // R7 size grow / shrink / page change
        wr(6'd5, 2'd0, 32'h0001_0330, 8'h22, 1, "R7 size grows");
        wr(6'd5, 2'd0, 32'h0001_0310, 8'h22, 0, "R7 size shrinks");
        wr(6'd5, 2'd0, 32'h0002_0310, 8'h22, 1, "R7 page changes");
        // R3 unencodable size code; R6 word3 alias write
        wr(6'd7, 2'd3, 32'h0040_02F0, 8'h01, 0, "R6 word3 alias write");
        rd(6'd7, 2'd0, 32'h0040_0210, 8'h01, "R3 size 15 stored as 1");
        sr(32'h0040_0FFF, 8'h01, 1, 6'd7, "R3 fallback page hit");
        sr(32'h0040_1000, 8'h01, 0, 6'h3F, "R3 fallback page miss");
        // R9 search concurrent with write sees old contents
        op(1, 0, 1, 6'd9, 2'd0, 32'h0080_0210, 8'h05, 32'h0080_0010, 8'h05);
        push(2, 0, 0, 0, "R7 concurrent write");
        push(1, {25'd0, 1'b0, 6'h3F}, 0, 0, "R9 concurrent search old view");
        sr(32'h0080_0010, 8'h05, 1, 6'd9, "R9 search after write");
        // R8 read concurrent with write returns old value
        op(1, 1, 0, 6'd9, 2'd1, 32'h1111_1000, 8'h00, 0, 0);
        push(0, 32'h0, 0, 0, "R8 concurrent read old value");
        push(2, 1, 0, 0, "R7 live rpn overwrite");
        rd(6'd9, 2'd1, 32'h1111_1000, 8'h00, "R8 read new value");
        // R7 invalidation
        wr(6'd9, 2'd0, 32'h0080_0010, 8'h05, 1, "R7 valid cleared");
        sr(32'h0080_0010, 8'h05, 0, 6'h3F, "R11 invalidated miss");
        wr(6'd9, 2'd0, 32'h0080_0010, 8'h05, 0, "R7 already invalid");
        // R1 / R11: index 63 boundary, index 0 untouched
        wr(6'd63, 2'd0, 32'h0100_0210, 8'h09, 0, "R1 top index write");
        sr(32'h0100_0004, 8'h09, 1, 6'd63, "R11 hit at index 63");
        rd(6'd63, 2'd0, 32'h0100_0210, 8'h09, "R1 top index read");
        rd(6'd0, 2'd0, 32'h0, 8'h00, "R1 index 0 untouched");
        idle();
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d pending exp 0", q.size());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule